// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each memory access presents a 16-bit virtual address and the identifier of the address space that is currently running. The upper byte of the address selects the virtual page and the lower byte is the offset within a 256-byte page. One cycle later the block reports a hit with the physical address, or a miss.

On a miss, the surrounding logic fetches the translation and writes it back through a refill port as an (address-space tag, virtual page, physical frame) triple. The block chooses which of its slots receives that write. A flush input empties every slot at once, for a context switch that does not rely on the tags.

Because every slot carries its own address-space tag, translations from several processes can be held at the same time. A lookup hits only when both the page number and the tag agree.

Top module: `asid_tlb`

## Requirements
- R1: After a synchronous active-high reset, `rsp_valid` is 0 and every slot is empty, so the first lookup of any address misses.
- R2: A lookup with `lk_valid` high gives `rsp_valid` high on the next cycle. A cycle with `lk_valid` low gives `rsp_valid` low on the next cycle.
- R3: A lookup hits only when some slot is valid, its page number equals `lk_vaddr[15:8]` and its tag equals `lk_asid`. On a hit, `rsp_paddr` is the slot's frame number in bits 15:8, with `lk_vaddr[7:0]` copied unchanged into bits 7:0.
- R4: On a miss, `rsp_hit` is 0 and `rsp_paddr` is 0. A slot whose page number matches but whose tag differs does not produce a hit.
- R5: A refill or flush takes effect at the clock edge that ends its cycle. A lookup issued in that same cycle is answered from the contents as they were before the change.
- R6: `flush` clears every slot. When `flush` and `rf_valid` are high in the same cycle, the refill is discarded and the replacement pointer does not move.
- R7: A refill whose tag and page number equal those of a valid slot rewrites that slot's frame number, so no duplicate slot is created.
- R8: Any other refill goes to the lowest-numbered empty slot. If no slot is empty, it goes to the slot named by a replacement pointer. The pointer resets to 0 and advances by one, wrapping from 7 to 0, on every refill that is not discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_asid | input | 8 | Address-space tag of the current process |
| rf_valid | input | 1 | Refill write request |
| rf_asid | input | 8 | Tag of the translation being written |
| rf_vpn | input | 8 | Virtual page number being written |
| rf_pfn | input | 8 | Physical frame number being written |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup response hit |
| rsp_paddr | output | 16 | Translated physical address, 0 on a miss |

## Verification
Some internal faults leave no immediate mark on the outputs. A stuck valid bit, a lost flush or a slot written with the wrong tag only appears when a later lookup names that exact page and tag; that lookup then hits where it should miss, or the reverse, one cycle after the request. A wrong replacement choice stays hidden even longer: it shows only once all slots are full and the evicted page is looked up again. The bench therefore revisits earlier pages after each refill and uses a small page and tag space in its random phase. It compares every response cycle with a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // where a refill write was directed
  typedef enum logic [1:0] {
    FILL_MATCH = 2'd0,   // rewrite slot holding same tag/page
    FILL_FREE  = 2'd1,   // lowest empty slot
    FILL_RR    = 2'd2    // replacement pointer
  } tlb_fill_src_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N      = 8,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 8,
  parameter int PFN_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] r_asid,
  input  logic [VPN_W-1:0]  r_vpn,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              flush,
  output logic [N-1:0]      hit_vec,
  output logic [N-1:0]      rf_match_vec,
  output logic [N-1:0]      valid_vec,
  output logic [PFN_W-1:0]  hit_pfn
);
  logic [N-1:0]      valid_q;
  logic [ASID_W-1:0] asid_q [N];
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];

  // payload: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      asid_q[wr_idx] <= r_asid;
      vpn_q[wr_idx]  <= r_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g]      = valid_q[g] && (asid_q[g] == q_asid) && (vpn_q[g] == q_vpn);
    assign rf_match_vec[g] = valid_q[g] && (asid_q[g] == r_asid) && (vpn_q[g] == r_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_pfn = hit_pfn | pfn_q[i];
  end

  assign valid_vec = valid_q;

  // R6: after a flush nothing is valid
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));
  // R7: in-place rewrite keeps tag/page pairs unique
  a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  a_r7_single_rf_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rf_match_vec));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [N-1:0]     rf_match_vec,
  input  logic [N-1:0]     valid_vec,
  output logic [IDX_W-1:0] victim_idx,
  output tlb_fill_src_e    victim_src
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] match_idx, free_idx;
  logic             match_found, free_found;

  always_comb begin
    match_found = 1'b0;
    match_idx   = '0;
    free_found  = 1'b0;
    free_idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rf_match_vec[i]) begin
        match_found = 1'b1;
        match_idx   = IDX_W'(i);
      end
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (match_found) begin
      victim_idx = match_idx;
      victim_src = FILL_MATCH;
    end else if (free_found) begin
      victim_idx = free_idx;
      victim_src = FILL_FREE;
    end else begin
      victim_idx = ptr_q;
      victim_src = FILL_RR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R8: pointer only moves on an accepted refill
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> $stable(ptr_q));
  // R8: the pointer is used only when every slot is occupied
  a_r8_free_first: assert property (@(posedge clk) disable iff (rst)
    (fill_en && victim_src == FILL_RR) |-> (&valid_vec));
  // R7: a matching slot is always chosen over a free or pointed slot
  a_r7_match_wins: assert property (@(posedge clk) disable iff (rst)
    (fill_en && (|rf_match_vec)) |-> (victim_src == FILL_MATCH));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PAGE_BITS = 8,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 8,
  parameter int N         = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PFN_W + PAGE_BITS,
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              rf_valid,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr
);
  logic [N-1:0]     hit_vec, rf_match_vec, valid_vec;
  logic [PFN_W-1:0] hit_pfn;
  logic [IDX_W-1:0] victim_idx;
  tlb_fill_src_e    victim_src;
  logic             fill_en;

  // flush wins over a refill in the same cycle
  assign fill_en = rf_valid && !flush;

  tlb_entry_store #(.N(N), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .q_asid       (lk_asid),
    .q_vpn        (lk_vaddr[VA_W-1:PAGE_BITS]),
    .r_asid       (rf_asid),
    .r_vpn        (rf_vpn),
    .wr_en        (fill_en),
    .wr_idx       (victim_idx),
    .wr_pfn       (rf_pfn),
    .flush        (flush),
    .hit_vec      (hit_vec),
    .rf_match_vec (rf_match_vec),
    .valid_vec    (valid_vec),
    .hit_pfn      (hit_pfn)
  );

  tlb_victim_sel #(.N(N)) u_victim (
    .clk          (clk),
    .rst          (rst),
    .fill_en      (fill_en),
    .rf_match_vec (rf_match_vec),
    .valid_vec    (valid_vec),
    .victim_idx   (victim_idx),
    .victim_src   (victim_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|hit_vec);
      rsp_paddr <= (lk_valid && (|hit_vec)) ? {hit_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;
    end
  end

  // R2: one response per request, one cycle later
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R3: offset passes through untouched
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));
  // R4: misses report a zero address
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
  a_r2_hit_has_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, rf_valid, flush;
  logic [15:0] lk_vaddr;
  logic [7:0]  lk_asid, rf_asid, rf_vpn, rf_pfn;
  logic        rsp_valid, rsp_hit;
  logic [15:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit   m_v   [8];
  int   m_asid[8];
  int   m_vpn [8];
  int   m_pfn [8];
  int   m_ptr = 0;

  always #5 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .rf_valid(rf_valid), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
    .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
  );

  task automatic model_fill(input int a, input int v, input int p);
    int slot = -1;
    for (int i = 0; i < 8; i++)
      if (slot < 0 && m_v[i] && m_asid[i] == a && m_vpn[i] == v) slot = i;
    for (int i = 0; i < 8; i++)
      if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) slot = m_ptr;
    m_v[slot] = 1'b1; m_asid[slot] = a; m_vpn[slot] = v; m_pfn[slot] = p;
    m_ptr = (m_ptr + 1) % 8;
  endtask

  // drive one cycle, predict, compare after the edge
  task automatic step(input bit lv, input logic [15:0] va, input logic [7:0] la,
                      input bit rv, input logic [7:0] ra, input logic [7:0] rvp,
                      input logic [7:0] rpf, input bit fl, input string tag);
    bit          e_hit = 1'b0;
    logic [15:0] e_pa  = 16'h0;
    lk_valid = lv; lk_vaddr = va; lk_asid = la;
    rf_valid = rv; rf_asid = ra; rf_vpn = rvp; rf_pfn = rpf; flush = fl;
    if (lv)
      for (int i = 0; i < 8; i++)
        if (m_v[i] && m_vpn[i] == int'(va[15:8]) && m_asid[i] == int'(la)) begin
          e_hit = 1'b1;
          e_pa  = {8'(m_pfn[i]), va[7:0]};
        end
    if (fl) begin
      for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
    end else if (rv) model_fill(int'(ra), int'(rvp), int'(rpf));
    @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== lv || rsp_hit !== e_hit || rsp_paddr !== e_pa) begin
      errors++;
      $display("FAIL %s: actual valid=%0b hit=%0b pa=%h expected valid=%0b hit=%0b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_paddr, lv, e_hit, e_pa);
    end
  endtask

  task automatic look(input logic [15:0] va, input logic [7:0] la, input string tag);
    step(1'b1, va, la, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, tag);
  endtask

  task automatic fill(input logic [7:0] a, input logic [7:0] v, input logic [7:0] p, input string tag);
    step(1'b0, 16'h0, 8'h0, 1'b1, a, v, p, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 0; lk_vaddr = 0; lk_asid = 0;
    rf_valid = 0; rf_asid = 0; rf_vpn = 0; rf_pfn = 0; flush = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
    end
    rst = 1'b0;

    look(16'hBB13, 8'd211, "R1 first lookup misses");
    step(1'b0, 16'h0, 8'h0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, "R2 idle no response");
    // refill with simultaneous lookup sees old contents
    step(1'b1, 16'hBB13, 8'd211, 1'b1, 8'd211, 8'hBB, 8'h91, 1'b0, "R5 lookup during refill");
    look(16'hBB13, 8'd211, "R3 hit 0xBB13->0x9113");
    look(16'hBB13, 8'd122, "R4 other tag misses");
    fill(8'd211, 8'hFF, 8'h23, "R8 fill slot1");
    fill(8'd122, 8'h05, 8'h91, "R8 fill slot2");
    look(16'hFF10, 8'd211, "R3 hit ff");
    look(16'h0519, 8'd122, "R3 hit 05 tag122");
    look(16'h0519, 8'd211, "R4 05 tag211 misses");
    fill(8'd211, 8'hBB, 8'h44, "R7 rewrite bb");
    look(16'hBBEE, 8'd211, "R7 rewritten frame");
    // fill remaining slots, then overflow into the pointer
    for (int i = 0; i < 8; i++) fill(8'd7, 8'(8'h10 + i), 8'(8'hA0 + i), "R8 fill many");
    for (int i = 0; i < 8; i++) look({8'(8'h10 + i), 8'h3C}, 8'd7, "R8 round-robin survivors");
    look(16'hBB01, 8'd211, "R8 evicted or kept bb");
    look(16'hFF02, 8'd211, "R8 evicted or kept ff");
    // flush with simultaneous refill and lookup
    step(1'b1, 16'h1701, 8'd7, 1'b1, 8'd9, 8'h99, 8'h55, 1'b1, "R6 flush beats refill, R5 lookup old");
    look(16'h9900, 8'd9, "R6 dropped refill absent");
    look(16'h1701, 8'd7, "R6 flushed entry gone");
    fill(8'd3, 8'h42, 8'h24, "R8 after flush uses slot0");
    look(16'h4281, 8'd3, "R3 hit after flush");
    step(1'b0, 16'h4281, 8'd3, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, "R2 idle again");

    for (int n = 0; n < 600; n++) begin
      bit lv = 1'($urandom_range(0, 3) != 0);
      bit rv = 1'($urandom_range(0, 2) == 0);
      bit fl = 1'($urandom_range(0, 40) == 0);
      step(lv, {8'($urandom_range(0, 11)), 8'($urandom_range(0, 255))}, 8'($urandom_range(1, 2)),
           rv, 8'($urandom_range(1, 2)), 8'($urandom_range(0, 11)), 8'($urandom_range(0, 255)),
           fl, "R3 R4 R7 R8 random traffic");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule